// File: doc/BRIEF.md
# Vertical Scaler Line-Fetch Controller

This block drives the input side of a five-tap vertical scaling filter that works on an image one column at a time. A column is at most 64 pixels wide. Five line buffers feed the filter. The controller decides which input line segments must be loaded into those buffers before each output line segment can be computed. It issues one block read per line and names the buffer slot that the read fills. It also tells the filter which slot feeds each tap and gives the fractional vertical phase for the interpolation.

A fixed-point U accumulator sets the fetch pattern. U has 4 integer bits and 8 fractional bits. After each output segment the increment is added to the fractional part of U. The integer carry of that sum is the number of new lines to fetch, so buffered lines are reused from one output line to the next. Nothing is copied between slots. A head pointer running modulo 5 picks the oldest slot, and the tap order is read relative to that pointer. Read addresses are produced by adding the line offset to the block field, which is the address above bit 6. The low six bits of the column start address are kept unchanged on every read, so a column does not have to start on a block boundary.

A column begins with a one-cycle `start` pulse. It ends after `n_lines` output segments have been announced on `seg_done`.

Top module: `vlf_ctrl`

## Requirements
- R1: After reset, `rd_valid` and `seg_done` are low. `tap_map` is the identity: field i, at bits [3i+2:3i], holds slot i.
- R2: A `start` pulse while idle begins a column. The first segment fetches exactly 5 blocks. Each read keeps the low 6 bits of `col_addr`. The block field (bits 31:6) starts at that of `col_addr` and grows by the block field of `line_off` after every accepted read.
- R3: Each read fills the slot given on `rd_slot`, which is the head pointer. The head then advances modulo 5. Tap field i of `tap_map` equals (head + i) mod 5, so tap 0 is the oldest line and tap 4 is the line fetched last.
- R4: At `start` the fractional part of U is loaded from `u_start[7:0]`, and `u_start[11:8]` is ignored. After each segment, U becomes the fractional part of (U + `u_inc`). `phase` shows the fractional part of U while `seg_done` is high.
- R5: After each segment except the last, the number of reads for the next segment is k = integer part of (U + `u_inc`), with U taken before the update. k may be 0. When k exceeds 5, only 5 reads are made, and the block field first skips (k − 5) line offsets.
- R6: `seg_done` is a one-cycle pulse. It is raised only after every read requested for that segment has been accepted, and never while `rd_valid` is high.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_addr` and `rd_slot` hold their values.
- R8: `line_off[5:0]` has no effect on any read address.
- R9: `rd_len` equals the `col_pix` value latched at `start`. Changes to `col_addr`, `line_off` or `col_pix` during a column have no effect.
- R10: After the `n_lines`-th `seg_done` the block goes idle and makes no more reads or pulses. A `start` pulse during a column is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a column (honoured while idle) |
| col_addr | input | 32 | Byte address of the first pixel of the column's top line |
| line_off | input | 32 | Address distance between lines, a multiple of 64 |
| u_start | input | 12 | Starting U value, 4.8 fixed point |
| u_inc | input | 12 | U increment per output segment, 4.8 fixed point |
| col_pix | input | 7 | Pixels in this column, 1 to 64 |
| n_lines | input | 12 | Output segments in this column |
| rd_valid | output | 1 | Block read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read address |
| rd_slot | output | 3 | Buffer slot that the read fills |
| rd_len | output | 7 | Pixel count of the read |
| tap_map | output | 15 | Slot feeding each of the five taps, 3 bits per tap |
| phase | output | 8 | Fractional vertical phase for the filter |
| seg_done | output | 1 | Buffers ready for one output segment |

## Verification
The bench targets upscaling. There the carry is 0 on every other segment, and a design that always fetched at least one line would show an extra read and a wrong tap order. A large increment makes the bench check both the clamp at 5 reads and the skipped line offsets. A design that forgot the skip would fetch lines that sit too high in the image. Back-pressure and an unaligned start address with stray offset bits show whether the address moves during a stall and whether the low address bits survive. A start pulse in mid-column, together with changed inputs, shows whether the design reloads or reads live inputs.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int NTAP      = 5;
  localparam int SLOT_W    = 3;
  localparam int MAX_FETCH = 5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT} vlf_state_t;

  // reads for one segment: carry clamped to the number of taps
  function automatic logic [2:0] clamp_fetch(input logic [7:0] carry);
    return (carry > 8'(MAX_FETCH)) ? 3'(MAX_FETCH) : carry[2:0];
  endfunction

  // lines passed over without a read when the carry exceeds the tap count
  function automatic logic [7:0] skip_lines(input logic [7:0] carry);
    return (carry > 8'(MAX_FETCH)) ? carry - 8'(MAX_FETCH) : 8'd0;
  endfunction

  function automatic logic [SLOT_W-1:0] next_head(input logic [SLOT_W-1:0] h);
    return (h == SLOT_W'(NTAP - 1)) ? '0 : h + 1'b1;
  endfunction

  // slot feeding tap i, counted from the oldest line
  function automatic logic [SLOT_W-1:0] slot_of(input logic [SLOT_W-1:0] h, input int i);
    logic [3:0] s;
    s = 4'(h) + 4'(i);
    if (s >= 4'(NTAP)) s = s - 4'(NTAP);
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/vlf_u_acc.sv
module vlf_u_acc #(
  parameter int UI = 4,
  parameter int UF = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [UF-1:0]  start_frac,
  input  logic [UI+UF-1:0] inc,
  output logic [UF-1:0]  frac,
  output logic [UI:0]    carry
);
  localparam int U_W = UI + UF;

  logic [U_W-1:0] inc_q;
  logic [UF-1:0]  frac_q;
  logic [U_W:0]   sum_w;

  assign sum_w = {1'b0, inc_q} + (U_W+1)'(frac_q);
  assign carry = sum_w[U_W:UF];
  assign frac  = frac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q  <= '0;
      frac_q <= '0;
    end else if (load) begin
      inc_q  <= inc;
      frac_q <= start_frac;
    end else if (step) begin
      frac_q <= sum_w[UF-1:0];
    end
  end
endmodule

// File: rtl/vlf_addr_gen.sv
module vlf_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 6,
  parameter int BLK_W   = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              skip_en,
  input  logic [7:0]        skip_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [BLK_W-1:0]  off_in,
  output logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  off_blk
);
  logic [BLK_W-1:0]   blk_q, off_q, step_w;
  logic [BLK_LSB-1:0] low_q;

  always_comb begin
    if (adv)          step_w = off_q;
    else if (skip_en) step_w = off_q * BLK_W'(skip_n);
    else              step_w = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      low_q <= '0;
      off_q <= '0;
    end else if (load) begin
      blk_q <= base[ADDR_W-1:BLK_LSB];
      low_q <= base[BLK_LSB-1:0];
      off_q <= off_in;
    end else begin
      blk_q <= blk_q + step_w;
    end
  end

  assign addr    = {blk_q, low_q};
  assign off_blk = off_q;
endmodule

// File: rtl/vlf_slot_ring.sv
module vlf_slot_ring
  import vlf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   adv,
  output logic [SLOT_W-1:0]      head,
  output logic [NTAP*SLOT_W-1:0] tap_map
);
  logic [SLOT_W-1:0] head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   head_q <= '0;
    else if (load) head_q <= '0;
    else if (adv)  head_q <= next_head(head_q);
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_map[i*SLOT_W +: SLOT_W] = slot_of(head_q, i);
  end

  assign head = head_q;
endmodule

// File: rtl/vlf_ctrl.sv
module vlf_ctrl
  import vlf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 6,
  parameter int UI      = 4,
  parameter int UF      = 8,
  parameter int PIX_W   = 7,
  parameter int LINE_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      col_addr,
  input  logic [ADDR_W-1:0]      line_off,
  input  logic [UI+UF-1:0]       u_start,
  input  logic [UI+UF-1:0]       u_inc,
  input  logic [PIX_W-1:0]       col_pix,
  input  logic [LINE_W-1:0]      n_lines,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [SLOT_W-1:0]      rd_slot,
  output logic [PIX_W-1:0]       rd_len,
  output logic [NTAP*SLOT_W-1:0] tap_map,
  output logic [UF-1:0]          phase,
  output logic                   seg_done
);
  localparam int U_W   = UI + UF;
  localparam int BLK_W = ADDR_W - BLK_LSB;

  vlf_state_t        state_q;
  logic [2:0]        left_q;
  logic [LINE_W-1:0] seg_q, n_q;
  logic [PIX_W-1:0]  pix_q;

  // named internal events
  logic        go_w, fetch_acc_w, last_w, seg_adv_w;
  logic [UI:0] carry_w;
  logic [7:0]  carry8_w;
  logic [BLK_W-1:0] off_blk_w;
  logic        unused_bits;

  assign go_w        = start && (state_q == S_IDLE);
  assign fetch_acc_w = rd_valid && rd_ready;
  assign last_w      = (seg_q + 1'b1) >= n_q;
  assign seg_adv_w   = (state_q == S_EMIT) && !last_w;
  assign carry8_w    = 8'(carry_w);
  assign unused_bits = ^{u_start[U_W-1:UF], line_off[BLK_LSB-1:0]};

  vlf_u_acc #(.UI(UI), .UF(UF)) u_uacc (
    .clk(clk), .rst_n(rst_n), .load(go_w), .step(seg_adv_w),
    .start_frac(u_start[UF-1:0]), .inc(u_inc),
    .frac(phase), .carry(carry_w)
  );

  vlf_addr_gen #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(go_w), .adv(fetch_acc_w),
    .skip_en(seg_adv_w), .skip_n(skip_lines(carry8_w)),
    .base(col_addr), .off_in(line_off[ADDR_W-1:BLK_LSB]),
    .addr(rd_addr), .off_blk(off_blk_w)
  );

  vlf_slot_ring u_ring (
    .clk(clk), .rst_n(rst_n), .load(go_w), .adv(fetch_acc_w),
    .head(rd_slot), .tap_map(tap_map)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      left_q  <= '0;
      seg_q   <= '0;
      n_q     <= '0;
      pix_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_FETCH;
          left_q  <= 3'(MAX_FETCH);
          seg_q   <= '0;
          n_q     <= n_lines;
          pix_q   <= col_pix;
        end
        S_FETCH: begin
          if (left_q == '0)     state_q <= S_EMIT;
          else if (fetch_acc_w) left_q  <= left_q - 1'b1;
        end
        S_EMIT: begin
          if (last_w) state_q <= S_IDLE;
          else begin
            state_q <= S_FETCH;
            left_q  <= clamp_fetch(carry8_w);
            seg_q   <= seg_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = (state_q == S_FETCH) && (left_q != '0);
  assign seg_done = (state_q == S_EMIT);
  assign rd_len   = pix_q;
endmodule

// File: rtl/vlf_chk.sv
module vlf_chk #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_valid,
  input logic                        rd_ready,
  input logic [ADDR_W-1:0]           rd_addr,
  input logic [2:0]                  rd_slot,
  input logic [2:0]                  tap_new,
  input logic                        seg_done,
  input logic [ADDR_W-BLK_LSB-1:0]   off_blk
);
  logic [3:0] fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fcnt_q <= '0;
    else if (seg_done)             fcnt_q <= '0;
    else if (rd_valid && rd_ready) fcnt_q <= fcnt_q + 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_slot));

  p_idle_bus_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> !rd_valid);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !seg_done);

  p_newest_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> tap_new == $past(rd_slot));

  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_slot < 3'd5);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=>
      rd_addr[ADDR_W-1:BLK_LSB] == $past(rd_addr[ADDR_W-1:BLK_LSB]) + $past(off_blk));

  p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rd_addr[BLK_LSB-1:0] == $past(rd_addr[BLK_LSB-1:0]));

  p_fetch_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> fcnt_q <= 4'd5);
endmodule

bind vlf_ctrl vlf_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .rd_slot(rd_slot), .tap_new(tap_map[14:12]),
  .seg_done(seg_done), .off_blk(off_blk_w)
);

// File: tb/sim_vlf_ctrl.sv
`timescale 1ns/1ps
module sim_vlf_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_ready = 1'b0;
  logic [31:0] col_addr = '0, line_off = '0;
  logic [11:0] u_start = '0, u_inc = '0, n_lines = '0;
  logic [6:0]  col_pix = '0;
  logic        rd_valid, seg_done;
  logic [31:0] rd_addr;
  logic [2:0]  rd_slot;
  logic [6:0]  rd_len;
  logic [14:0] tap_map;
  logic [7:0]  phase;

  int n_chk = 0, n_fail = 0, wd = 0;

  always #4 clk = ~clk;

  vlf_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .col_addr(col_addr), .line_off(line_off),
    .u_start(u_start), .u_inc(u_inc), .col_pix(col_pix), .n_lines(n_lines),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_slot(rd_slot),
    .rd_len(rd_len), .tap_map(tap_map), .phase(phase), .seg_done(seg_done)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired: act=%0d exp<=150000", wd);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] taps_for(input int h);
    logic [14:0] m;
    for (int i = 0; i < 5; i++) m[i*3 +: 3] = 3'((h + i) % 5);
    return m;
  endfunction

  // one column, checked against an independent model
  task automatic run_col(input logic [31:0] ca, input logic [31:0] off,
                         input logic [11:0] us, input logic [11:0] ui,
                         input logic [6:0] px, input int nl, input int stall, input bit poke);
    logic [25:0] blk, oblk;
    logic [5:0]  low;
    int frac, head, need, got, segs, cyc, sum, k;
    @(negedge clk);
    col_addr = ca; line_off = off; u_start = us; u_inc = ui; col_pix = px;
    n_lines = 12'(nl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blk = ca[31:6]; low = ca[5:0]; oblk = off[31:6];
    frac = int'(us[7:0]); head = 0; need = 5; got = 0; segs = 0; cyc = 0;
    while (segs < nl && cyc < 5000) begin
      if (poke && cyc == 3) begin
        start = 1'b1; col_addr = 32'hDEAD_BE00; line_off = 32'h40; col_pix = 7'd3;
      end
      if (poke && cyc == 4) start = 1'b0;
      if (seg_done) begin
        chk(got == need, "R6", "reads before seg_done", 64'(got), 64'(need));
        chk(phase == 8'(frac), "R4", "phase", 64'(phase), 64'(frac));
        chk(tap_map == taps_for(head), "R3", "tap_map", 64'(tap_map), 64'(taps_for(head)));
        segs++;
        sum = frac + int'(ui);
        k = sum >> 8;
        frac = sum & 255;
        need = (k > 5) ? 5 : k;
        if (k > 5) blk = blk + 26'(k - 5) * oblk;   // R5 skipped lines
        got = 0;
      end
      if (rd_valid) begin
        chk(got < need, "R5", "read count", 64'(got + 1), 64'(need));
        chk(rd_addr == {blk, low}, "R2", "rd_addr", 64'(rd_addr), 64'({blk, low}));
        chk(rd_slot == 3'(head), "R3", "rd_slot", 64'(rd_slot), 64'(head));
        chk(rd_len == px, "R9", "rd_len", 64'(rd_len), 64'(px));
        rd_ready = (stall == 0) || ((cyc % stall) != 0);
        if (rd_ready) begin
          blk = blk + oblk; head = (head + 1) % 5; got++;
        end
      end else rd_ready = 1'b0;
      @(negedge clk);
      cyc++;
    end
    rd_ready = 1'b0;
    chk(segs == nl, "R10", "segments in column", 64'(segs), 64'(nl));
    for (int i = 0; i < 4; i++) begin
      chk(!rd_valid && !seg_done, "R10", "quiet after column",
          64'({rd_valid, seg_done}), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !seg_done, "R1", "outputs in reset", 64'({rd_valid, seg_done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !seg_done, "R1", "outputs after reset", 64'({rd_valid, seg_done}), 64'd0);
    chk(tap_map == taps_for(0), "R1", "identity tap_map", 64'(tap_map), 64'(taps_for(0)));
  endtask

  // R2 R3: scale 1.0, one read per segment, full ready
  task automatic t_unity();
    run_col(32'h0001_0000, 32'h0000_0400, 12'h000, 12'h100, 7'd64, 6, 0, 1'b0);
  endtask

  // R7 R9 R10: scale 1/2, unaligned start, stalls, mid-column start and input changes
  task automatic t_down();
    run_col(32'h0002_0013, 32'h0000_0A00, 12'h000, 12'h200, 7'd45, 5, 3, 1'b1);
  endtask

  // R4 R5: scale 2.0, alternate segments need no read
  task automatic t_up();
    run_col(32'h0003_0000, 32'h0000_0800, 12'h040, 12'h080, 7'd64, 7, 2, 1'b0);
  endtask

  // R4 R5 R8: carry above 5, integer bits of u_start and low offset bits ignored
  task automatic t_clamp();
    run_col(32'h0004_0021, 32'h0000_0C3F, 12'hF30, 12'h7C0, 7'd17, 4, 0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_unity();
    t_down();
    t_up();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule